// File: doc/BRIEF.md
# Warp Lane Shuffle Unit

This block moves 32-bit words between the lanes of one warp in a single clocked step, so that lanes can trade register values without a round trip through shared storage. Every lane presents one word, and one operation code with one operand applies to the whole warp. The unit works out, for each destination lane, which lane to read from, then takes that lane's word. Four ways of choosing the source are offered: a broadcast from one indexed lane, a shift towards higher lanes, a shift towards lower lanes, and an XOR butterfly for FFT-style exchange patterns.

A lane-enable vector marks which lanes hold live data. A destination whose source lies outside the warp, or whose source lane is disabled, gets back its own word and a cleared per-lane valid flag. Results are registered. An operation strobed on `i_go` appears after the next rising edge, and a new operation can be strobed on every cycle.

A two-state controller runs the output stage. `SHF_IDLE` means no fresh result is presented and all valid flags are low. `SHF_LOADED` means the output registers hold the result of the operation strobed on the previous edge. The transition *accept* (any state to `SHF_LOADED`) is taken whenever `i_go` is high. The transition *drain* (any state to `SHF_IDLE`) is taken whenever `i_go` is low. `SHF_LOADED` is held across back-to-back strobes, and reset forces `SHF_IDLE`.

Top module: `warp_shuffle_unit`

## Requirements
- R1: With `i_mode` = 2'b00 (indexed), every lane k receives the word of lane s = `i_operand[4:0]`. Its valid flag is set when lane s is enabled.
- R2: In indexed mode, bits of `i_operand` above bit 4 have no effect on which lane is read.
- R3: With `i_mode` = 2'b01 (up), lane k reads lane k − d, where d is the full `i_operand` value. A lane with k < d keeps its own word and its valid flag is cleared.
- R4: With `i_mode` = 2'b10 (down), lane k reads lane k + d. A lane with k + d > 31 keeps its own word and its valid flag is cleared.
- R5: With `i_mode` = 2'b11 (XOR), lane k reads lane k XOR `i_operand[4:0]`. Higher operand bits are ignored.
- R6: A lane whose source lane has its `i_active` bit low receives its own word and a cleared valid flag. The destination's own `i_active` bit plays no part.
- R7: The result of an operation strobed on `i_go` is on `o_data`/`o_lane_ok` after the next rising edge. Strobes on consecutive cycles each produce their own result one cycle later.
- R8: On an edge where `i_go` is low, `o_data` holds its previous value and every `o_lane_ok` bit goes low.
- R9: While `rst_n` is low, `o_data` is all zero and `o_lane_ok` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| i_go | input | 1 | Operation strobe, one operation per cycle |
| i_mode | input | 2 | 00 indexed, 01 up, 10 down, 11 XOR |
| i_operand | input | 8 | Lane index, shift distance or XOR mask |
| i_active | input | 32 | Per-lane enable, bit k for lane k |
| i_data | input | 32x32 | Lane words, element k for lane k |
| o_data | output | 32x32 | Registered result words, element k for lane k |
| o_lane_ok | output | 32 | Registered per-lane valid flags |

## Verification
The embedded assertions check, on every cycle, the properties that hold whatever the data is. A low strobe leaves the result words unchanged and clears all flags. Valid flags only appear while the controller reports a loaded result. In the three injective modes, the number of valid lanes never exceeds the number of enabled lanes. Which word lands in which lane can only be shown by the bench scenarios, compared against the behavioural model: boundary shift distances of 0, 31 and beyond 31, operand bits above bit 4, XOR masks, and partly disabled source lanes.

// File: rtl/warp_shuffle_pkg.sv
package warp_shuffle_pkg;

    typedef enum logic [1:0] {
        SHF_IDX  = 2'b00,
        SHF_UP   = 2'b01,
        SHF_DOWN = 2'b10,
        SHF_XOR  = 2'b11
    } shf_mode_e;

    typedef enum logic {
        SHF_IDLE   = 1'b0,
        SHF_LOADED = 1'b1
    } shf_state_e;

endpackage

// File: rtl/shf_src_select.sv
module shf_src_select
    import warp_shuffle_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int OPND_W  = 8,
    parameter int LANE_ID = 0,
    localparam int LANE_W = $clog2(LANES)
) (
    input  shf_mode_e            mode_i,
    input  logic [OPND_W-1:0]    operand_i,
    output logic [LANE_W-1:0]    src_o,
    output logic                 in_range_o
);
    localparam int SUM_W = OPND_W + 2;

    logic [SUM_W-1:0] lane_ext;
    logic [SUM_W-1:0] opnd_ext;
    logic [SUM_W-1:0] sum_ext;
    logic [LANE_W-1:0] low_bits;

    assign lane_ext = SUM_W'(LANE_ID);
    assign opnd_ext = SUM_W'(operand_i);
    assign sum_ext  = lane_ext + opnd_ext;
    assign low_bits = operand_i[LANE_W-1:0];

    always_comb begin
        src_o      = LANE_W'(LANE_ID);
        in_range_o = 1'b1;
        unique case (mode_i)
            SHF_IDX: begin
                src_o = low_bits;
            end
            SHF_UP: begin
                in_range_o = (opnd_ext <= lane_ext);
                src_o      = LANE_W'(LANE_ID) - low_bits;
            end
            SHF_DOWN: begin
                in_range_o = (sum_ext <= SUM_W'(LANES - 1));
                src_o      = LANE_W'(LANE_ID) + low_bits;
            end
            SHF_XOR: begin
                src_o = LANE_W'(LANE_ID) ^ low_bits;
            end
            default: begin
                src_o      = LANE_W'(LANE_ID);
                in_range_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shf_crossbar.sv
module shf_crossbar #(
    parameter int LANES   = 32,
    parameter int DATA_W  = 32,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0][DATA_W-1:0] data_i,
    input  logic [LANES-1:0][LANE_W-1:0] src_i,
    input  logic [LANES-1:0]             in_range_i,
    input  logic [LANES-1:0]             active_i,
    output logic [LANES-1:0][DATA_W-1:0] data_o,
    output logic [LANES-1:0]             ok_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic take_src;
        assign take_src  = in_range_i[k] && active_i[src_i[k]];
        assign ok_o[k]   = take_src;
        assign data_o[k] = take_src ? data_i[src_i[k]] : data_i[k];
    end

endmodule

// File: rtl/warp_shuffle_unit.sv
module warp_shuffle_unit
    import warp_shuffle_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int DATA_W = 32,
    parameter int OPND_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          i_go,
    input  logic [1:0]                    i_mode,
    input  logic [OPND_W-1:0]             i_operand,
    input  logic [LANES-1:0]              i_active,
    input  logic [LANES-1:0][DATA_W-1:0]  i_data,
    output logic [LANES-1:0][DATA_W-1:0]  o_data,
    output logic [LANES-1:0]              o_lane_ok
);
    localparam int LANE_W = $clog2(LANES);

    shf_mode_e                    mode;
    shf_state_e                   state_q, state_d;
    logic [LANES-1:0][LANE_W-1:0] src;
    logic [LANES-1:0]             in_range;
    logic [LANES-1:0][DATA_W-1:0] xbar_data;
    logic [LANES-1:0]             xbar_ok;

    assign mode = shf_mode_e'(i_mode);

    for (genvar k = 0; k < LANES; k++) begin : g_src
        shf_src_select #(
            .LANES   (LANES),
            .OPND_W  (OPND_W),
            .LANE_ID (k)
        ) src_i (
            .mode_i     (mode),
            .operand_i  (i_operand),
            .src_o      (src[k]),
            .in_range_o (in_range[k])
        );
    end

    shf_crossbar #(
        .LANES  (LANES),
        .DATA_W (DATA_W)
    ) xbar_i (
        .data_i     (i_data),
        .src_i      (src),
        .in_range_i (in_range),
        .active_i   (i_active),
        .data_o     (xbar_data),
        .ok_o       (xbar_ok)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SHF_IDLE:   state_d = i_go ? SHF_LOADED : SHF_IDLE;
            SHF_LOADED: state_d = i_go ? SHF_LOADED : SHF_IDLE;
            default:    state_d = SHF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SHF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_data    <= '0;
            o_lane_ok <= '0;
        end else if (state_d == SHF_LOADED) begin
            o_data    <= xbar_data;
            o_lane_ok <= xbar_ok;
        end else begin
            o_lane_ok <= '0;
        end
    end

    // R8: an edge without a strobe keeps the words
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !i_go |=> $stable(o_data));

    // R8: an edge without a strobe clears every flag
    assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !i_go |=> (o_lane_ok == '0));

    // R7: flags only while a loaded result is presented
    assert_flags_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_lane_ok != '0) |-> (state_q == SHF_LOADED));

    // R6: injective modes cannot yield more valid lanes than enabled lanes
    assert_ok_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (i_go && (i_mode != SHF_IDX)) |=>
            ($countones(o_lane_ok) <= $countones($past(i_active))));

    // R1: indexed mode gives either all flags or none
    assert_idx_uniform_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (i_go && (i_mode == SHF_IDX)) |=>
            ((o_lane_ok == '0) || (o_lane_ok == '1)));

endmodule

// File: tb/warp_shuffle_unit_tb_top.sv
module warp_shuffle_unit_tb_top;
    localparam int LANES = 32;
    localparam int DW    = 32;
    localparam int OW    = 8;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       i_go = 1'b0;
    logic [1:0]                 i_mode = 2'b00;
    logic [OW-1:0]              i_operand = '0;
    logic [LANES-1:0]           i_active = '0;
    logic [LANES-1:0][DW-1:0]   i_data = '0;
    logic [LANES-1:0][DW-1:0]   o_data;
    logic [LANES-1:0]           o_lane_ok;

    int checks = 0;
    int errors = 0;

    logic [LANES-1:0][DW-1:0] exp_data = '0;
    logic [LANES-1:0]         exp_ok = '0;

    always #2 clk = ~clk;

    warp_shuffle_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .i_go      (i_go),
        .i_mode    (i_mode),
        .i_operand (i_operand),
        .i_active  (i_active),
        .i_data    (i_data),
        .o_data    (o_data),
        .o_lane_ok (o_lane_ok)
    );

    function automatic logic [DW-1:0] word(int seed, int lane);
        return DW'(seed * 32'h0100_0000 + lane * 32'h0001_0101 + seed * 7 + 1);
    endfunction

    // Behavioural reference: one result per strobed cycle, held otherwise.
    task automatic model_step(input logic go, input logic [1:0] mode,
                              input int opnd, input logic [LANES-1:0] act,
                              input logic [LANES-1:0][DW-1:0] dat);
        if (!go) begin
            exp_ok = '0;
            return;
        end
        for (int k = 0; k < LANES; k++) begin
            int s;
            case (mode)
                2'b00:   s = opnd % 32;
                2'b01:   s = k - opnd;
                2'b10:   s = k + opnd;
                default: s = k ^ (opnd % 32);
            endcase
            if (s >= 0 && s < LANES && act[s]) begin
                exp_data[k] = dat[s];
                exp_ok[k]   = 1'b1;
            end else begin
                exp_data[k] = dat[k];
                exp_ok[k]   = 1'b0;
            end
        end
    endtask

    task automatic compare(input string req);
        checks++;
        if (o_data !== exp_data) begin
            errors++;
            for (int k = 0; k < LANES; k++)
                if (o_data[k] !== exp_data[k]) begin
                    $display("FAIL %s data lane %0d actual %h expected %h",
                             req, k, o_data[k], exp_data[k]);
                    break;
                end
        end
        checks++;
        if (o_lane_ok !== exp_ok) begin
            errors++;
            $display("FAIL %s lane_ok actual %h expected %h", req, o_lane_ok, exp_ok);
        end
    endtask

    task automatic step(input logic go, input logic [1:0] mode, input int opnd,
                        input logic [LANES-1:0] act, input int seed, input string req);
        @(negedge clk);
        i_go      = go;
        i_mode    = mode;
        i_operand = OW'(opnd);
        i_active  = act;
        for (int k = 0; k < LANES; k++) i_data[k] = word(seed, k);
        model_step(go, mode, opnd, act, i_data);
        @(posedge clk);
        #1;
        compare(req);
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < LANES; k++) i_data[k] = word(9, k);
        i_go = 1'b1;
        i_active = '1;
        repeat (3) @(posedge clk);
        #1;
        exp_data = '0;
        exp_ok   = '0;
        compare("R9");
        @(negedge clk);
        rst_n = 1'b1;
        i_go  = 1'b0;

        step(1'b1, 2'b00, 7,     '1, 1, "R1");
        step(1'b1, 2'b00, 8'hE3, '1, 2, "R2");
        step(1'b1, 2'b01, 5,     '1, 3, "R3");
        step(1'b1, 2'b01, 0,     '1, 4, "R3");
        step(1'b1, 2'b10, 31,    '1, 5, "R4");
        step(1'b1, 2'b10, 40,    '1, 6, "R4");
        step(1'b1, 2'b10, 3,     '1, 7, "R4");
        step(1'b1, 2'b11, 1,     '1, 8, "R5");
        step(1'b1, 2'b11, 8'h3F, '1, 9, "R5");
        step(1'b1, 2'b00, 4,     32'hFFFF_FFEF, 10, "R6");
        step(1'b1, 2'b00, 4,     32'h0000_0010, 11, "R6");
        step(1'b1, 2'b01, 2,     32'h0F0F_3355, 12, "R6");
        step(1'b1, 2'b11, 16,    32'h0000_FFFF, 13, "R6");
        step(1'b0, 2'b11, 5,     '1, 14, "R8");
        step(1'b0, 2'b00, 0,     '1, 15, "R8");
        step(1'b1, 2'b10, 1,     '1, 16, "R7");
        step(1'b1, 2'b01, 1,     '1, 17, "R7");
        step(1'b1, 2'b00, 31,    '1, 18, "R7");
        step(1'b0, 2'b00, 0,     '0, 19, "R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule